// File: doc/BRIEF.md
# Packet Header ECC Encoder and Corrector

This block guards the 24-bit header of a serial-link packet. The header holds an identifier byte in bits [7:0] and two data or length bytes in bits [23:8]. In encode mode it forms the 8-bit check byte that goes in bits [31:24]. In decode mode it takes a received 32-bit header and recomputes six parity bits over the data. It compares them with the received ones to form a syndrome. From the syndrome it repairs any single flipped bit, whether that bit is in the data or in the check byte, and it flags two-bit damage as uncorrectable.

Each request arrives as a one-cycle `in_valid` pulse with a mode bit and a header. The answer appears on registered outputs exactly one clock later, qualified by `out_valid`. The identifier byte of the resulting header is also split into a 2-bit channel number (bits [7:6]) and a 6-bit type code (bits [5:0]).

Control is a three-state result machine. `ST_IDLE` means no result is held. `ST_ENC` holds an encode result. `ST_DEC` holds a decode result. From any state, a cycle with `in_valid` high and `in_decode` low moves to `ST_ENC`, and one with `in_valid` and `in_decode` both high moves to `ST_DEC`. A cycle with `in_valid` low moves to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `hdr_ecc_top`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low; results of back-to-back requests appear on consecutive cycles.
- R2: Encode output is `{2'b00, P[5:0], D[23:0]}`, where D is `in_hdr[23:0]` and each Pk is the XOR of these data bits: P0 {0,1,2,4,5,7,10,11,13,16,20,21,22,23}, P1 {0,1,3,4,6,8,10,12,14,17,20,21,22,23}, P2 {0,2,3,5,6,9,11,12,15,18,20,21,22}, P3 {1,2,3,7,8,9,13,14,15,19,20,21,23}, P4 {4..9,16..20,22,23}, P5 {10..19,21,22,23}.
- R3: `out_vc` equals `out_hdr[7:6]` and `out_dt` equals `out_hdr[5:0]` whenever `out_valid` is high.
- R4: A decoded header whose bits [29:24] match the parity of its bits [23:0] gives a zero syndrome, both correction flags low, and `out_hdr[29:0]` unchanged.
- R5: A decoded header with exactly one data bit flipped is returned with that bit restored and the check byte set to `{2'b00, P}`, with `out_corrected` high and `out_uncorrectable` low.
- R6: A decoded header with exactly one of bits [29:24] flipped keeps its data bits unchanged, has its check byte restored to `{2'b00, P}`, and raises `out_corrected`.
- R7: Any two flipped bits among [29:0] raise `out_uncorrectable`, keep `out_corrected` low, and pass the whole received header to `out_hdr` unchanged.
- R8: In decode mode, `out_rsvd_warn` is high exactly when received bits [31:30] are not both zero. Those bits play no part in the syndrome or the correction.
- R9: In decode mode, `out_syndrome` equals received bits [29:24] XOR the parity (per R2) of received bits [23:0].
- R10: After reset, `out_valid`, `out_corrected`, `out_uncorrectable`, `out_rsvd_warn` and `out_syndrome` are all zero.
- R11: In encode mode, input bits [31:24] are ignored, and the syndrome and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_decode | input | 1 | 1 = check and correct, 0 = generate check byte |
| in_hdr | input | 32 | Header; bits [31:24] used only when decoding |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_hdr | output | 32 | Encoded or corrected header |
| out_vc | output | 2 | Channel number from the result identifier byte |
| out_dt | output | 6 | Type code from the result identifier byte |
| out_syndrome | output | 6 | Decode syndrome, zero in encode mode |
| out_corrected | output | 1 | A single-bit error was repaired |
| out_uncorrectable | output | 1 | Damage beyond one bit was detected |
| out_rsvd_warn | output | 1 | Received top two check bits were not zero |

## Verification
A result machine stuck in the wrong state shows up one cycle after the request. `out_valid` fails to follow `in_valid`, or decode flags appear on an encode result. A wrong parity equation changes the encoded check byte for some data patterns. It also makes clean headers look damaged or repairs the wrong bit, which shows in `out_hdr` and `out_syndrome` at the next edge. The bench therefore sweeps single-bit and two-bit faults across many positions in both data and check bits.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;

    localparam int DATA_W = 24;
    localparam int PAR_W  = 6;
    localparam int ECC_W  = 8;
    localparam int HDR_W  = DATA_W + ECC_W;
    localparam int RSV_W  = ECC_W - PAR_W;

    // Data-bit membership of each parity bit, index k = parity bit k.
    localparam logic [DATA_W-1:0] PAR_MASK [PAR_W] = '{
        24'hF12CB7,
        24'hF2555B,
        24'h749A6D,
        24'hB8E38E,
        24'hDF03F0,
        24'hEFFC00
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENC,
        ST_DEC
    } res_state_e;

    // Syndrome produced by an error in data bit idx.
    function automatic logic [PAR_W-1:0] col_of(input int idx);
        logic [PAR_W-1:0] c;
        for (int k = 0; k < PAR_W; k++) begin
            c[k] = PAR_MASK[k][idx];
        end
        return c;
    endfunction

endpackage

// File: rtl/hdr_parity_gen.sv
module hdr_parity_gen
    import hdr_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  parity
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        assign parity[k] = ^(data & PAR_MASK[k]);
    end

endmodule

// File: rtl/hdr_syndrome_fix.sv
module hdr_syndrome_fix
    import hdr_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] rx_data,
    input  logic [PAR_W-1:0]  rx_par,
    input  logic [PAR_W-1:0]  calc_par,
    output logic [DATA_W-1:0] fixed_data,
    output logic [PAR_W-1:0]  syndrome,
    output logic              data_err,
    output logic              par_err,
    output logic              uncorr
);

    logic [DATA_W-1:0] hit;
    logic              syn_nz;

    assign syndrome = rx_par ^ calc_par;
    assign syn_nz   = |syndrome;

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        assign hit[i] = (syndrome == col_of(i));
    end

    assign fixed_data = rx_data ^ hit;
    assign data_err   = |hit;
    assign par_err    = syn_nz && ((syndrome & (syndrome - 1'b1)) == '0);
    assign uncorr     = syn_nz && !data_err && !par_err;

    always_comb begin
        if (!$isunknown(syndrome)) begin
            AST_ONE_DATA_FIX: assert ($onehot0(hit)); // R5
            AST_CLASS_EXCL: assert ($countones({data_err, par_err, uncorr}) <= 1); // R7
        end
    end

endmodule

// File: rtl/hdr_ecc_top.sv
module hdr_ecc_top
    import hdr_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_decode,
    input  logic [HDR_W-1:0] in_hdr,
    output logic             out_valid,
    output logic [HDR_W-1:0] out_hdr,
    output logic [1:0]       out_vc,
    output logic [5:0]       out_dt,
    output logic [PAR_W-1:0] out_syndrome,
    output logic             out_corrected,
    output logic             out_uncorrectable,
    output logic             out_rsvd_warn
);

    res_state_e state_q, state_d;

    logic [DATA_W-1:0] rx_data;
    logic [PAR_W-1:0]  rx_par;
    logic [RSV_W-1:0]  rx_rsv;
    logic [PAR_W-1:0]  calc_par;
    logic [DATA_W-1:0] fix_data;
    logic [PAR_W-1:0]  syn;
    logic              dec_data_err;
    logic              dec_par_err;
    logic              dec_uncorr;

    logic [HDR_W-1:0]  res_hdr_d, res_hdr_q;
    logic [PAR_W-1:0]  syn_q;
    logic              corr_q, unc_q, warn_q;

    assign rx_data = in_hdr[DATA_W-1:0];
    assign rx_par  = in_hdr[DATA_W +: PAR_W];
    assign rx_rsv  = in_hdr[HDR_W-1 -: RSV_W];

    hdr_parity_gen u_par (
        .data   (rx_data),
        .parity (calc_par)
    );

    hdr_syndrome_fix u_fix (
        .rx_data    (rx_data),
        .rx_par     (rx_par),
        .calc_par   (calc_par),
        .fixed_data (fix_data),
        .syndrome   (syn),
        .data_err   (dec_data_err),
        .par_err    (dec_par_err),
        .uncorr     (dec_uncorr)
    );

    // Next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) begin
            state_d = in_decode ? ST_DEC : ST_ENC;
        end
    end

    // Result header selection
    always_comb begin
        if (!in_decode) begin
            res_hdr_d = {{RSV_W{1'b0}}, calc_par, rx_data};
        end else if (dec_uncorr) begin
            res_hdr_d = in_hdr;
        end else if (dec_par_err) begin
            res_hdr_d = {{RSV_W{1'b0}}, calc_par, rx_data};
        end else begin
            res_hdr_d = {{RSV_W{1'b0}}, rx_par, fix_data};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hdr_q <= '0;
            syn_q     <= '0;
            corr_q    <= 1'b0;
            unc_q     <= 1'b0;
            warn_q    <= 1'b0;
        end else if (in_valid) begin
            res_hdr_q <= res_hdr_d;
            syn_q     <= syn;
            corr_q    <= dec_data_err || dec_par_err;
            unc_q     <= dec_uncorr;
            warn_q    <= |rx_rsv;
        end
    end

    // Output process
    always_comb begin
        out_valid         = 1'b0;
        out_syndrome      = '0;
        out_corrected     = 1'b0;
        out_uncorrectable = 1'b0;
        out_rsvd_warn     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ENC: begin
                out_valid = 1'b1;
            end
            ST_DEC: begin
                out_valid         = 1'b1;
                out_syndrome      = syn_q;
                out_corrected     = corr_q;
                out_uncorrectable = unc_q;
                out_rsvd_warn     = warn_q;
            end
            default: begin
            end
        endcase
        out_hdr = res_hdr_q;
        out_vc  = res_hdr_q[7:6];
        out_dt  = res_hdr_q[5:0];
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ENC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_decode) |=> (!out_corrected && !out_uncorrectable && out_syndrome == '0)); // R11
    AST_UNCORR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_decode && dec_uncorr) |=> (out_hdr == $past(in_hdr))); // R7
    AST_PARERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_decode && dec_par_err) |=> (out_hdr[DATA_W-1:0] == $past(in_hdr[DATA_W-1:0]))); // R6
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_corrected && out_uncorrectable)); // R5
    AST_WARN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_decode) |=> (out_rsvd_warn == ($past(in_hdr[HDR_W-1 -: RSV_W]) != '0))); // R8

endmodule

// File: tb/hdr_ecc_top_tb.sv
module hdr_ecc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_decode = 1'b0;
    logic [31:0] in_hdr = '0;
    logic        out_valid;
    logic [31:0] out_hdr;
    logic [1:0]  out_vc;
    logic [5:0]  out_dt;
    logic [5:0]  out_syndrome;
    logic        out_corrected;
    logic        out_uncorrectable;
    logic        out_rsvd_warn;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hdr_ecc_top u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .in_valid          (in_valid),
        .in_decode         (in_decode),
        .in_hdr            (in_hdr),
        .out_valid         (out_valid),
        .out_hdr           (out_hdr),
        .out_vc            (out_vc),
        .out_dt            (out_dt),
        .out_syndrome      (out_syndrome),
        .out_corrected     (out_corrected),
        .out_uncorrectable (out_uncorrectable),
        .out_rsvd_warn     (out_rsvd_warn)
    );

    localparam int NV = 8;
    localparam logic [23:0] V_DATA [NV] = '{
        24'h000000, 24'hFFFFFF, 24'h0A0529, 24'h123456,
        24'hA5C3F0, 24'h800001, 24'h5A5A5A, 24'h0C3B81
    };
    localparam int V_FA [NV] = '{0, 23, 7, 12, 20, 1, 15, 22};
    localparam int V_FB [NV] = '{1, 0, 19, 3, 21, 22, 16, 9};

    // Parity per R2, built from the listed bit sets.
    function automatic logic [5:0] ref_par(input logic [23:0] d);
        logic [5:0] p;
        p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        p[4] = (^d[9:4]) ^ (^d[20:16]) ^ d[22] ^ d[23];
        p[5] = (^d[19:10]) ^ d[21] ^ d[22] ^ d[23];
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; outputs are sampled at the falling edge after the capture edge.
    task automatic request(input logic dec, input logic [31:0] hdr);
        @(negedge clk);
        in_valid  = 1'b1;
        in_decode = dec;
        in_hdr    = hdr;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic expect_dec(input string req, input logic [31:0] hdr, input logic [5:0] syn,
                              input logic corr, input logic unc, input logic warn);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " hdr"}, out_hdr, hdr);
        check({req, " syndrome"}, {26'd0, out_syndrome}, {26'd0, syn});
        check({req, " flags"}, {29'd0, out_corrected, out_uncorrectable, out_rsvd_warn},
              {29'd0, corr, unc, warn});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 valid", {31'd0, out_valid}, 32'd0);
        check("R10 flags", {26'd0, out_syndrome, out_corrected, out_uncorrectable, out_rsvd_warn}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] d;
            logic [7:0]  e;
            logic [23:0] ma, mb;
            logic [5:0]  mp;
            d  = V_DATA[v];
            e  = {2'b00, ref_par(d)};
            ma = 24'd1 << V_FA[v];
            mb = 24'd1 << V_FB[v];
            mp = 6'd1 << (V_FA[v] % 6);

            // R2, R11: encode, junk in upper byte ignored
            request(1'b0, {8'hA5 ^ 8'(v), d});
            check("R2 enc hdr", out_hdr, {e, d});
            check("R11 enc quiet", {26'd0, out_syndrome, out_corrected, out_uncorrectable, out_rsvd_warn}, 32'd0);
            check("R3 fields", {24'd0, out_vc, out_dt}, {24'd0, d[7:0]});
            check("R1 enc valid", {31'd0, out_valid}, 32'd1);

            // R4, R9: clean decode
            request(1'b1, {e, d});
            expect_dec("R4 clean", {e, d}, 6'd0, 1'b0, 1'b0, 1'b0);

            // R5, R9: single data bit
            request(1'b1, {e, d ^ ma});
            expect_dec("R5 data fix", {e, d}, e[5:0] ^ ref_par(d ^ ma), 1'b1, 1'b0, 1'b0);
            check("R3 fixed fields", {24'd0, out_vc, out_dt}, {24'd0, d[7:0]});

            // R6: single parity bit
            request(1'b1, {e ^ {2'b00, mp}, d});
            expect_dec("R6 par fix", {e, d}, mp, 1'b1, 1'b0, 1'b0);

            // R7: two data bits
            request(1'b1, {e, d ^ ma ^ mb});
            expect_dec("R7 two data", {e, d ^ ma ^ mb}, e[5:0] ^ ref_par(d ^ ma ^ mb), 1'b0, 1'b1, 1'b0);

            // R7: one data bit plus one parity bit
            request(1'b1, {e ^ {2'b00, mp}, d ^ mb});
            expect_dec("R7 data+par", {e ^ {2'b00, mp}, d ^ mb}, e[5:0] ^ mp ^ ref_par(d ^ mb), 1'b0, 1'b1, 1'b0);
        end

        // R8: reserved bits set on a clean header
        begin
            logic [23:0] d;
            logic [5:0]  p;
            d = 24'h3C9A17;
            p = ref_par(d);
            request(1'b1, {2'b10, p, d});
            expect_dec("R8 warn clean", {2'b00, p, d}, 6'd0, 1'b0, 1'b0, 1'b1);
            request(1'b1, {2'b01, p, d ^ 24'h000100});
            expect_dec("R8 warn fix", {2'b00, p, d}, p ^ ref_par(d ^ 24'h000100), 1'b1, 1'b0, 1'b1);
            request(1'b1, {2'b00, p, d});
            check("R8 warn clear", {31'd0, out_rsvd_warn}, 32'd0);
        end

        // R1: back-to-back requests, then a gap
        @(negedge clk);
        in_valid = 1'b1; in_decode = 1'b0; in_hdr = 32'h0000_0041;
        @(negedge clk);
        check("R1 b2b first", out_hdr, {2'b00, ref_par(24'h000041), 24'h000041});
        in_decode = 1'b1; in_hdr = {2'b00, ref_par(24'h00FF00), 24'h00FF00};
        @(negedge clk);
        check("R1 b2b second valid", {31'd0, out_valid}, 32'd1);
        check("R1 b2b second hdr", out_hdr, {2'b00, ref_par(24'h00FF00), 24'h00FF00});
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 gap", {31'd0, out_valid}, 32'd0);
        check("R10 idle flags", {29'd0, out_corrected, out_uncorrectable, out_rsvd_warn}, 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule